// File: doc/BRIEF.md
# Multi-PLL Bring-Up Sequencer

This block is a hardware state machine that takes four clock PLLs from their reset condition to running operation after a single start pulse. The four are a spread-spectrum PLL, a charge-pump filter PLL, an IO filter PLL and the main nest PLL. Each PLL has three control outputs: test enable, reset and bypass. Besides these, the block drives a clock-input mux select, a buffer drive-strength field and a pair of pulse-mode controls.

When it sees the start pulse, the block captures its configuration. That configuration gives a bypass flag for each PLL, a sync-mode flag, the drive strength and the pulse settings. The block then walks through a fixed series of one-cycle steps. For each PLL it starts, it releases the PLL's controls in a set order and waits a programmable settle time. It then samples a synchronized 4-bit lock input once and releases that PLL's bypass only if the PLL has locked.

A missing lock stops the sequence and raises an error code that names the failing PLL. A run in which all four PLLs were started finishes by pulsing a clear for the error status and then unmasking unlock-error reporting.

Top module: `pll_bringup_seq`

## Requirements
- R1: The first step after start loads `drive_str` from the captured drive setting. Only when the captured pulse-enable flag is 1 do two further steps follow: one raises `pulse_en`, and the next loads `pulse_mode`.
- R2: PLLs are handled in the order index 0 (spread spectrum), 1 (charge-pump filter), 2 (IO filter), 3 (nest). A PLL whose `cfg_bypass` bit is 1 takes no cycles, and its three control bits are left unchanged.
- R3: For a started PLL with index 0 to 2, consecutive cycles do the following: test enable goes low, then reset goes low, then SETTLE_CYC waiting cycles pass, then a lock-check cycle, then bypass goes low.
- R4: Bit k of `lock_in` is the lock of PLL index k. It passes through a two-flop synchronizer and is sampled once, in the lock-check cycle.
- R5: If the lock bit is low in the check cycle, the sequence stops. `err_valid` goes to 1 and `err_code` becomes the PLL index plus 1 (1 to 4). That PLL's bypass stays high, no later step runs, and `busy` drops in the same cycle.
- R6: For the nest PLL, test enable is lowered first (only if not bypassed). The next step sets `clkin_sel` to 1 when the captured sync mode is 1 and otherwise leaves it unchanged. This step runs even when the nest PLL is bypassed. After it come reset release, wait, check and bypass release, which happen only when the nest PLL is not bypassed.
- R7: Only when all four bypass flags are 0 and every lock check passed, `err_status_clr` pulses for one cycle. In the next cycle `unlock_err_mask` goes low and stays low until reset.
- R8: While `rst_n` is low, all test enables, resets and bypasses are 1. `clkin_sel`, `drive_str`, `pulse_en`, `pulse_mode`, `err_status_clr`, `busy`, `done`, `err_valid` and `err_code` are 0, and `unlock_err_mask` is 1.
- R9: A start pulse while idle captures every configuration input and raises `busy` one cycle later. A start pulse while busy, and any configuration change during a run, have no effect.
- R10: `done` rises in the cycle after the last step of a successful run. Both `done` and the error outputs are held until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, accepted when idle |
| cfg_bypass | input | 4 | Per-PLL skip flags, bit k = PLL index k |
| cfg_sync_mode | input | 1 | 1 selects the nest clock input on the mux |
| cfg_drive | input | DRV_W | Buffer drive strength to load |
| cfg_pulse_en | input | 1 | Enables the pulse-mode steps |
| cfg_pulse_mode | input | PM_W | Pulse-mode value to load |
| lock_in | input | 4 | Asynchronous PLL lock flags, bit k = PLL index k |
| pll_test_en | output | 4 | Per-PLL test enable |
| pll_reset | output | 4 | Per-PLL reset |
| pll_bypass | output | 4 | Per-PLL bypass |
| clkin_sel | output | 1 | Clock-input mux select |
| drive_str | output | DRV_W | Buffer drive strength |
| pulse_en | output | 1 | Pulse-mode enable |
| pulse_mode | output | PM_W | Pulse-mode value |
| err_status_clr | output | 1 | One-cycle clear of the error status |
| unlock_err_mask | output | 1 | Masks unlock-error reporting while high |
| busy | output | 1 | Sequence running |
| done | output | 1 | Last run completed without error |
| err_valid | output | 1 | Last run stopped on a lock failure |
| err_code | output | 3 | 0 none, 1 to 4 failing PLL index plus 1 |

## Verification
A wrong state or index inside the sequencer shows up at the control ports within one cycle. A skipped or repeated step leaves one of the twelve per-PLL control bits off its expected position. A wrong index releases a neighbour's bit. A miscounted settle window moves the lock check and the bypass release by whole cycles. The reference trace predicts every output on every cycle, so any such slip is reported in the cycle it first appears. A lock sampled from the wrong bit or at the wrong time either stops a healthy run early or lets a failing PLL's bypass drop, and both are visible at once in the bypass bits and in `err_code`.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
   localparam int unsigned PLL_CNT  = 4;
   localparam int unsigned NEST_IDX = 3;
   localparam int unsigned CODE_W   = 3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DRV,
      ST_PE_ON,
      ST_PM_LOAD,
      ST_TE_OFF,
      ST_MUX,
      ST_RST_OFF,
      ST_WAIT,
      ST_CHECK,
      ST_BYP_OFF,
      ST_CLR_ERR,
      ST_UNMASK,
      ST_FINISH
   } seq_state_e;

   // First PLL at or after index 'from' that must be started:
   // {1, idx} means test-enable step for idx, {0, 3} means go to mux step.
   function automatic logic [2:0] pick_next(input logic [3:0] byp, input logic [2:0] from);
      logic [2:0] r;
      r = 3'b011;
      if (!byp[NEST_IDX]) r = 3'b111;
      for (int k = 2; k >= 0; k--) begin
         if (3'(k) >= from && !byp[k]) r = {1'b1, 2'(k)};
      end
      return r;
   endfunction
endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pbs_settle_timer.sv
module pbs_settle_timer #(
   parameter int unsigned CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int unsigned CNT_W = $clog2(CYC + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= CNT_W'(CYC - 1);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
   import pbs_pkg::*;
#(
   parameter int unsigned DRV_W = 4,
   parameter int unsigned PM_W  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [PLL_CNT-1:0]  cfg_bypass,
   input  logic                cfg_sync_mode,
   input  logic [DRV_W-1:0]    cfg_drive,
   input  logic                cfg_pulse_en,
   input  logic [PM_W-1:0]     cfg_pulse_mode,
   input  logic [PLL_CNT-1:0]  lock_s,
   input  logic                tmr_expired,
   output logic                tmr_load,
   output logic [PLL_CNT-1:0]  pll_test_en,
   output logic [PLL_CNT-1:0]  pll_reset,
   output logic [PLL_CNT-1:0]  pll_bypass,
   output logic                clkin_sel,
   output logic [DRV_W-1:0]    drive_str,
   output logic                pulse_en,
   output logic [PM_W-1:0]     pulse_mode,
   output logic                err_status_clr,
   output logic                unlock_err_mask,
   output logic                busy,
   output logic                done,
   output logic                err_valid,
   output logic [CODE_W-1:0]   err_code
);
   seq_state_e        state;
   logic [1:0]        idx;
   logic [PLL_CNT-1:0] c_byp;
   logic              c_sync;
   logic [DRV_W-1:0]  c_drv;
   logic              c_pe;
   logic [PM_W-1:0]   c_pm;
   logic [2:0]        nxt_first;
   logic [2:0]        nxt_after;
   logic              nest_last;

   assign nxt_first = pick_next(c_byp, 3'd0);
   assign nxt_after = pick_next(c_byp, {1'b0, idx} + 3'd1);
   assign nest_last = (idx == 2'(NEST_IDX));
   assign tmr_load  = (state == ST_RST_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state           <= ST_IDLE;
         idx             <= '0;
         c_byp           <= '0;
         c_sync          <= 1'b0;
         c_drv           <= '0;
         c_pe            <= 1'b0;
         c_pm            <= '0;
         pll_test_en     <= '1;
         pll_reset       <= '1;
         pll_bypass      <= '1;
         clkin_sel       <= 1'b0;
         drive_str       <= '0;
         pulse_en        <= 1'b0;
         pulse_mode      <= '0;
         err_status_clr  <= 1'b0;
         unlock_err_mask <= 1'b1;
         busy            <= 1'b0;
         done            <= 1'b0;
         err_valid       <= 1'b0;
         err_code        <= '0;
      end else begin
         err_status_clr <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               c_byp     <= cfg_bypass;
               c_sync    <= cfg_sync_mode;
               c_drv     <= cfg_drive;
               c_pe      <= cfg_pulse_en;
               c_pm      <= cfg_pulse_mode;
               busy      <= 1'b1;
               done      <= 1'b0;
               err_valid <= 1'b0;
               err_code  <= '0;
               state     <= ST_DRV;
            end
            ST_DRV: begin
               drive_str <= c_drv;
               if (c_pe) state <= ST_PE_ON;
               else begin
                  state <= nxt_first[2] ? ST_TE_OFF : ST_MUX;
                  idx   <= nxt_first[1:0];
               end
            end
            ST_PE_ON: begin
               pulse_en <= 1'b1;
               state    <= ST_PM_LOAD;
            end
            ST_PM_LOAD: begin
               pulse_mode <= c_pm;
               state      <= nxt_first[2] ? ST_TE_OFF : ST_MUX;
               idx        <= nxt_first[1:0];
            end
            ST_TE_OFF: begin
               pll_test_en[idx] <= 1'b0;
               state            <= nest_last ? ST_MUX : ST_RST_OFF;
            end
            ST_MUX: begin
               if (c_sync) clkin_sel <= 1'b1;
               state <= c_byp[NEST_IDX] ? ST_FINISH : ST_RST_OFF;
            end
            ST_RST_OFF: begin
               pll_reset[idx] <= 1'b0;
               state          <= ST_WAIT;
            end
            ST_WAIT: if (tmr_expired) state <= ST_CHECK;
            ST_CHECK: begin
               if (lock_s[idx]) state <= ST_BYP_OFF;
               else begin
                  err_valid <= 1'b1;
                  err_code  <= CODE_W'({1'b0, idx} + 3'd1);
                  busy      <= 1'b0;
                  state     <= ST_IDLE;
               end
            end
            ST_BYP_OFF: begin
               pll_bypass[idx] <= 1'b0;
               if (nest_last) state <= (c_byp == '0) ? ST_CLR_ERR : ST_FINISH;
               else begin
                  state <= nxt_after[2] ? ST_TE_OFF : ST_MUX;
                  idx   <= nxt_after[1:0];
               end
            end
            ST_CLR_ERR: begin
               err_status_clr <= 1'b1;
               state          <= ST_UNMASK;
            end
            ST_UNMASK: begin
               unlock_err_mask <= 1'b0;
               state           <= ST_FINISH;
            end
            ST_FINISH: begin
               busy  <= 1'b0;
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
   import pbs_pkg::*;
#(
   parameter int unsigned SETTLE_CYC  = 1000,
   parameter int unsigned DRV_W       = 4,
   parameter int unsigned PM_W        = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [3:0]       cfg_bypass,
   input  logic             cfg_sync_mode,
   input  logic [DRV_W-1:0] cfg_drive,
   input  logic             cfg_pulse_en,
   input  logic [PM_W-1:0]  cfg_pulse_mode,
   input  logic [3:0]       lock_in,
   output logic [3:0]       pll_test_en,
   output logic [3:0]       pll_reset,
   output logic [3:0]       pll_bypass,
   output logic             clkin_sel,
   output logic [DRV_W-1:0] drive_str,
   output logic             pulse_en,
   output logic [PM_W-1:0]  pulse_mode,
   output logic             err_status_clr,
   output logic             unlock_err_mask,
   output logic             busy,
   output logic             done,
   output logic             err_valid,
   output logic [2:0]       err_code
);
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DRV_W < 1 || PM_W < 1) begin : g_bad_width
      $error("field widths must be at least 1");
   end

   logic [PLL_CNT-1:0] lock_s;
   logic               tmr_load;
   logic               tmr_expired;

   pbs_sync #(.W(PLL_CNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (lock_in),
      .q     (lock_s)
   );

   pbs_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .expired (tmr_expired)
   );

   pbs_fsm #(.DRV_W(DRV_W), .PM_W(PM_W)) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .start           (start),
      .cfg_bypass      (cfg_bypass),
      .cfg_sync_mode   (cfg_sync_mode),
      .cfg_drive       (cfg_drive),
      .cfg_pulse_en    (cfg_pulse_en),
      .cfg_pulse_mode  (cfg_pulse_mode),
      .lock_s          (lock_s),
      .tmr_expired     (tmr_expired),
      .tmr_load        (tmr_load),
      .pll_test_en     (pll_test_en),
      .pll_reset       (pll_reset),
      .pll_bypass      (pll_bypass),
      .clkin_sel       (clkin_sel),
      .drive_str       (drive_str),
      .pulse_en        (pulse_en),
      .pulse_mode      (pulse_mode),
      .err_status_clr  (err_status_clr),
      .unlock_err_mask (unlock_err_mask),
      .busy            (busy),
      .done            (done),
      .err_valid       (err_valid),
      .err_code        (err_code)
   );
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
   parameter int unsigned DRV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [3:0]       pll_test_en,
   input logic [3:0]       pll_reset,
   input logic [3:0]       pll_bypass,
   input logic             clkin_sel,
   input logic [DRV_W-1:0] drive_str,
   input logic             err_status_clr,
   input logic             unlock_err_mask,
   input logic             busy,
   input logic             done,
   input logic             err_valid,
   input logic [2:0]       err_code
);
   assert_err_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (err_code >= 3'd1 && err_code <= 3'd4));

   assert_code_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !err_valid |-> (err_code == 3'd0));

   assert_status_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && (done || err_valid)));

   assert_unmask_follows_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_status_clr |=> (!unlock_err_mask && !err_status_clr));

   assert_sel_rise_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clkin_sel) |-> $past(busy));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(drive_str) && $stable(pll_bypass) && $stable(clkin_sel)));

   for (genvar g = 0; g < 4; g++) begin : g_pll
      assert_rst_after_te_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pll_reset[g]) |-> !pll_test_en[g]);
      assert_byp_after_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pll_bypass[g]) |-> (!pll_reset[g] && !pll_test_en[g]));
   end
endmodule

bind pll_bringup_seq pbs_checker #(.DRV_W(DRV_W)) u_pbs_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .start           (start),
   .pll_test_en     (pll_test_en),
   .pll_reset       (pll_reset),
   .pll_bypass      (pll_bypass),
   .clkin_sel       (clkin_sel),
   .drive_str       (drive_str),
   .err_status_clr  (err_status_clr),
   .unlock_err_mask (unlock_err_mask),
   .busy            (busy),
   .done            (done),
   .err_valid       (err_valid),
   .err_code        (err_code)
);

// File: tb/pll_bringup_seq_test.sv
module pll_bringup_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 6;
   localparam int DW         = 4;
   localparam int PW         = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [3:0] cfg_bypass = '0;
   logic cfg_sync_mode = 1'b0;
   logic [DW-1:0] cfg_drive = '0;
   logic cfg_pulse_en = 1'b0;
   logic [PW-1:0] cfg_pulse_mode = '0;
   logic [3:0] lock_in = '0;
   logic [3:0] pll_test_en, pll_reset, pll_bypass;
   logic clkin_sel, pulse_en, err_status_clr, unlock_err_mask, busy, done, err_valid;
   logic [DW-1:0] drive_str;
   logic [PW-1:0] pulse_mode;
   logic [2:0] err_code;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_bringup_seq #(.SETTLE_CYC(SETTLE), .DRV_W(DW), .PM_W(PW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_bypass(cfg_bypass),
      .cfg_sync_mode(cfg_sync_mode), .cfg_drive(cfg_drive), .cfg_pulse_en(cfg_pulse_en),
      .cfg_pulse_mode(cfg_pulse_mode), .lock_in(lock_in), .pll_test_en(pll_test_en),
      .pll_reset(pll_reset), .pll_bypass(pll_bypass), .clkin_sel(clkin_sel),
      .drive_str(drive_str), .pulse_en(pulse_en), .pulse_mode(pulse_mode),
      .err_status_clr(err_status_clr), .unlock_err_mask(unlock_err_mask),
      .busy(busy), .done(done), .err_valid(err_valid), .err_code(err_code)
   );

   // expected port values
   logic [3:0] e_te, e_rst, e_byp;
   logic e_sel, e_pe, e_clr, e_mask, e_busy, e_done, e_ev;
   logic [DW-1:0] e_drv;
   logic [PW-1:0] e_pm;
   logic [2:0] e_code;
   logic [27:0] q[$];
   logic [27:0] cur;
   int vectors = 0;
   int miscompares = 0;

   function automatic logic [27:0] snap();
      return {e_te, e_rst, e_byp, e_sel, e_drv, e_pe, e_pm, e_clr, e_mask, e_busy, e_done, e_ev, e_code};
   endfunction

   task automatic push();
      q.push_back(snap());
   endtask

   task automatic reset_expect();   // R8 reset values
      e_te = 4'hF; e_rst = 4'hF; e_byp = 4'hF; e_sel = 0; e_drv = '0; e_pe = 0;
      e_pm = '0; e_clr = 0; e_mask = 1; e_busy = 0; e_done = 0; e_ev = 0; e_code = '0;
   endtask

   task automatic chk(input string req, input string name, input int a, input int e);
      vectors++;
      if (a != e) begin
         miscompares++;
         $display("FAIL %s %s at %0t: actual %0h expected %0h", req, name, $time, a, e);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      if (q.size() > 0) cur = q.pop_front();
      chk("R3", "test_en",  int'(pll_test_en),     int'(cur[27:24]));
      chk("R3", "reset",    int'(pll_reset),       int'(cur[23:20]));
      chk("R3", "bypass",   int'(pll_bypass),      int'(cur[19:16]));
      chk("R6", "clkin_sel",int'(clkin_sel),       int'(cur[15]));
      chk("R1", "drive",    int'(drive_str),       int'(cur[14:11]));
      chk("R1", "pulse_en", int'(pulse_en),        int'(cur[10]));
      chk("R1", "pulse_mode",int'(pulse_mode),     int'(cur[9:8]));
      chk("R7", "err_clr",  int'(err_status_clr),  int'(cur[7]));
      chk("R7", "err_mask", int'(unlock_err_mask), int'(cur[6]));
      chk("R9", "busy",     int'(busy),            int'(cur[5]));
      chk("R10", "done",    int'(done),            int'(cur[4]));
      chk("R5", "err_valid",int'(err_valid),       int'(cur[3]));
      chk("R5", "err_code", int'(err_code),        int'(cur[2:0]));
   endtask

   // Behavioural trace of one run: one snapshot per clock after the start edge.
   task automatic plan_run(input logic [3:0] byp, input logic sync, input logic [DW-1:0] drv,
                           input logic pe, input logic [PW-1:0] pm, input logic [3:0] lk);
      bit ok = 1;
      e_busy = 1; e_done = 0; e_ev = 0; e_code = '0; push();
      e_drv = drv; push();
      if (pe) begin e_pe = 1; push(); e_pm = pm; push(); end
      for (int k = 0; k < 4; k++) begin
         bit go = ok;
         if (go && k == 3) begin
            if (!byp[3]) begin e_te[3] = 0; push(); end
            if (sync) e_sel = 1;
            push();
            if (byp[3]) go = 0;
         end else if (go) begin
            if (byp[k]) go = 0;
            else begin e_te[k] = 0; push(); end
         end
         if (go) begin
            e_rst[k] = 0; push();
            repeat (SETTLE) push();
            if (!lk[k]) begin
               e_ev = 1; e_code = 3'(k + 1); e_busy = 0; push(); ok = 0;
            end else begin
               push(); e_byp[k] = 0; push();
            end
         end
      end
      if (ok) begin
         if (byp == 4'h0) begin e_clr = 1; push(); e_clr = 0; e_mask = 0; push(); end
         e_busy = 0; e_done = 1; push();
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      start = 0;
      reset_expect();
      q.delete();
      cur = snap();
      cyc(); cyc();
      rst_n = 1;
      cyc();
   endtask

   task automatic launch(input logic [3:0] byp, input logic sync, input logic [DW-1:0] drv,
                         input logic pe, input logic [PW-1:0] pm, input logic [3:0] lk);
      cfg_bypass = byp; cfg_sync_mode = sync; cfg_drive = drv;
      cfg_pulse_en = pe; cfg_pulse_mode = pm; lock_in = lk;
      cyc(); cyc(); cyc();
      start = 1;
      plan_run(byp, sync, drv, pe, pm, lk);
      cyc();
      start = 0;
   endtask

   task automatic drain();
      while (q.size() > 0) cyc();
      repeat (3) cyc();
   endtask

   initial begin
      reset_expect();
      cur = snap();
      do_reset();                                        // R8 reset state

      // full run, pulse mode on, sync mode: R1 R2 R3 R4 R6 R7 R10
      launch(4'h0, 1'b1, 4'hA, 1'b1, 2'b10, 4'hF);
      // R9: config changes and a second start during the run are ignored
      cfg_drive = 4'h5; cfg_bypass = 4'hF; cfg_pulse_en = 0; cfg_sync_mode = 0;
      repeat (5) cyc();
      start = 1; cyc(); start = 0;
      drain();

      // R10 restart without reset, sync 0 leaves clkin_sel set (R6)
      launch(4'h0, 1'b0, 4'h3, 1'b0, 2'b00, 4'hF);
      drain();

      // R2: PLLs 0 and 2 skipped, error mask stays set (R7)
      do_reset();
      launch(4'b0101, 1'b0, 4'h7, 1'b1, 2'b01, 4'hF);
      drain();

      // R5 R4: charge-pump filter PLL (bit 1) never locks, code 2
      do_reset();
      launch(4'h0, 1'b1, 4'h2, 1'b0, 2'b00, 4'b1101);
      drain();
      // R10: start after error clears error outputs, full run
      launch(4'h0, 1'b0, 4'h9, 1'b0, 2'b00, 4'hF);
      drain();

      // R5 R6: nest PLL (bit 3) fails after mux step, code 4
      do_reset();
      launch(4'b0010, 1'b1, 4'h1, 1'b0, 2'b00, 4'b0111);
      drain();

      // R6 R2: all bypassed, only drive and mux steps
      do_reset();
      launch(4'hF, 1'b1, 4'hC, 1'b0, 2'b00, 4'h0);
      drain();

      // R2: nest bypassed, others started, sync 0
      do_reset();
      launch(4'b1000, 1'b0, 4'h6, 1'b1, 2'b11, 4'h7);
      drain();

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule